// File: doc/BRIEF.md
# DDR DQ/DQS Data Datapath

This block sits between a single-data-rate user side and the double-data-rate data lines of a DDR memory. The user side presents one word per user clock that is twice the DQ width. For writes, the upper half is sent in the rising-edge beat and the lower half in the falling-edge beat. Data is launched from clocks shifted by 90 and 270 degrees. The block sources a DQS strobe whose edges sit in the middle of each beat, and drives the per-byte data-mask lines beside the data. Output enables let the pad logic tristate DQ and DQS outside a burst. DQS is driven low for one user cycle as a preamble and for half a cycle as a postamble.

For reads, the memory returns DQS with its edges lined up with the data transitions. An external delay line, set by calibration, shifts that strobe into the middle of the data valid window. The delayed strobe is the write clock of two small capture FIFOs. One FIFO holds the samples taken on rising strobe edges and the other holds the samples taken on falling edges. Each DQ bit has its own column in both FIFOs, and the columns of one FIFO share a pointer. Gray-coded write pointers cross into the user clock. When both FIFOs hold data, one entry is popped from each, and the pair is presented as one full-width read word with a valid flag.

Top module: `ddr_dq_datapath`

## Requirements
- R1: After reset `dq_oe`, `dqs_oe`, `dqs_o` and `rd_valid` are all 0.
- R2: Each user cycle with `wr_valid` high produces exactly one DQS period on `dqs_o`. The sampled `wr_data[2*DQ_W-1:DQ_W]` appears on `dq_o` at the DQS rising edge, and `wr_data[DQ_W-1:0]` appears at the following falling edge.
- R3: `dq_o` is stable for at least a quarter of the user clock period before every DQS edge of a write burst, so each strobe edge sits at the centre of its beat.
- R4: `wr_mask` bit `DM_W+i` masks byte i of the rising beat, and bit `i` masks byte i of the falling beat. Byte i is `dq[8i+7:8i]`. A mask bit of 1 drives `dm_o[i]` high during that beat, and the memory keeps its old contents for that byte.
- R5: `dqs_oe` rises exactly one user clock period before the first DQS rising edge of a burst, and `dqs_o` stays low during that preamble.
- R6: `dqs_oe` falls half a period after the last DQS falling edge, with `dqs_o` low. `dq_oe` is high at every DQS edge of a burst and is already low when `dqs_oe` falls. Both enables are low while idle.
- R7: Each rising `rd_strobe` edge captures `dq_i` into the rising FIFO, and each falling edge captures it into the falling FIFO. Read words come out in arrival order as `{rising sample, falling sample}`.
- R8: A read word is popped only when both FIFOs are non-empty. A read burst of N strobe periods yields exactly N words with `rd_valid` high, and no others.
- R9: Each capture FIFO holds FIFO_DEPTH entries. The synchronized Gray write pointer changes by at most one bit per user clock, and the occupancy seen by the user clock never exceeds FIFO_DEPTH under back-to-back read beats.
- R10: Read data is correct for any delayed-strobe phase inside the data valid window, with the strobe asynchronous to the user clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock; its edges time the DQS edges |
| clk90 | input | 1 | User clock shifted by 90 degrees; its falling edge is the 270-degree launch |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat pair present this cycle |
| wr_data | input | 2*DQ_W | Upper half goes in the rising beat, lower half in the falling beat |
| wr_mask | input | 2*DM_W | Per-byte mask; upper half for the rising beat, 1 = do not store |
| dq_o | output | DQ_W | DDR data toward the pads |
| dq_oe | output | 1 | DQ output enable |
| dm_o | output | DM_W | Data-mask lines toward the pads |
| dqs_o | output | 1 | Write strobe toward the pads |
| dqs_oe | output | 1 | DQS output enable, covering preamble and postamble |
| dq_i | input | DQ_W | DDR data from the pads |
| rd_strobe | input | 1 | Read DQS after the calibrated delay |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 2*DQ_W | {rising sample, falling sample} |

## Verification
On every user clock, the assertions check four things. The data enable never stands without the strobe enable. DQS is low when its enable first rises. Each synchronized Gray pointer moves by at most one bit. The occupancy seen from the user side never exceeds the FIFO depth. Only the scenarios can show the rest. These cover the placement of data against the strobe edges, the preamble and postamble lengths, the per-byte masking, and the correctness and ordering of read data at randomized strobe phases. The bench's memory model records what the block drives, and the read bursts replay that data.

// File: rtl/ddr_dq_datapath.sv
module ddr_dq_datapath #(
  parameter int DQ_W       = 16,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  clk90,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [2*DQ_W-1:0]     wr_data,
  input  logic [2*(DQ_W/BYTE_W)-1:0] wr_mask,
  output logic [DQ_W-1:0]       dq_o,
  output logic                  dq_oe,
  output logic [DQ_W/BYTE_W-1:0] dm_o,
  output logic                  dqs_o,
  output logic                  dqs_oe,
  input  logic [DQ_W-1:0]       dq_i,
  input  logic                  rd_strobe,
  output logic                  rd_valid,
  output logic [2*DQ_W-1:0]     rd_data
);
  localparam int DM_W = DQ_W / BYTE_W;
  localparam int WW   = 2 * DQ_W;
  localparam int MW   = 2 * DM_W;
  localparam int AW   = $clog2(FIFO_DEPTH);
  localparam int PW   = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write launch ----------------
  logic          s1_v, s2_v;
  logic [WW-1:0] s1_d;
  logic [MW-1:0] s1_m;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s1_d <= '0;
      s1_m <= '0;
    end else begin
      s1_v <= wr_valid;
      s2_v <= s1_v;
      s1_d <= wr_data;
      s1_m <= wr_mask;
    end

  logic [DQ_W-1:0] rise_q, low_hold, fall_q;
  logic [DM_W-1:0] mrise_q, mlow_hold, mfall_q;
  logic            oe270;

  always_ff @(negedge clk90 or negedge rst_n)
    if (!rst_n) begin
      rise_q    <= '0;
      low_hold  <= '0;
      mrise_q   <= '0;
      mlow_hold <= '0;
      oe270     <= 1'b0;
    end else begin
      rise_q    <= s1_d[WW-1:DQ_W];
      low_hold  <= s1_d[DQ_W-1:0];
      mrise_q   <= s1_m[MW-1:DM_W];
      mlow_hold <= s1_m[DM_W-1:0];
      oe270     <= s1_v;
    end

  always_ff @(posedge clk90 or negedge rst_n)
    if (!rst_n) begin
      fall_q  <= '0;
      mfall_q <= '0;
    end else begin
      fall_q  <= low_hold;
      mfall_q <= mlow_hold;
    end

  assign dq_o  = clk90 ? fall_q  : rise_q;
  assign dm_o  = clk90 ? mfall_q : mrise_q;
  assign dq_oe = oe270;

  logic tgl_r, tgl_f;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tgl_r <= 1'b0;
    else        tgl_r <= tgl_r ^ s1_v;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) tgl_f <= 1'b0;
    else        tgl_f <= tgl_r;

  assign dqs_o  = tgl_r ^ tgl_f;
  assign dqs_oe = s1_v | s2_v;

  // R6
  oe_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);

  // R5
  preamble_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe) |-> !dqs_o);

  // ---------------- read capture ----------------
  logic [1:0]           nonempty;
  logic [1:0][DQ_W-1:0] head;
  logic                 pop;

  assign pop = &nonempty;

  for (genvar e = 0; e < 2; e++) begin : g_edge
    logic            sclk;
    logic [PW-1:0]   wbin, wgray, wnxt;
    logic [PW-1:0]   gs1, gs2, rbin, rgray, occ;
    logic [DQ_W-1:0] mem [FIFO_DEPTH];

    assign sclk = rd_strobe ^ 1'(e);
    assign wnxt = wbin + 1'b1;

    always_ff @(posedge sclk or negedge rst_n)
      if (!rst_n) begin
        wbin  <= '0;
        wgray <= '0;
      end else begin
        wbin  <= wnxt;
        wgray <= wnxt ^ (wnxt >> 1);
      end

    always_ff @(posedge sclk)
      mem[wbin[AW-1:0]] <= dq_i;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        gs1  <= '0;
        gs2  <= '0;
        rbin <= '0;
      end else begin
        gs1 <= wgray;
        gs2 <= gs1;
        if (pop) rbin <= rbin + 1'b1;
      end

    assign rgray       = rbin ^ (rbin >> 1);
    assign nonempty[e] = (gs2 != rgray);
    assign head[e]     = mem[rbin[AW-1:0]];
    assign occ         = g2b(gs2) - rbin;

    // R9
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gs1 ^ $past(gs1)) <= 1);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= FIFO_DEPTH);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pop;
      if (pop) rd_data <= {head[0], head[1]};
    end

endmodule

// File: tb/ddr_dq_datapath_tb.sv
`timescale 1ns/1ps
module ddr_dq_datapath_tb_top;
  localparam int  DQ_W = 16;
  localparam int  DM_W = 2;
  localparam real T    = 5.0;

  logic clk = 1'b0, clk90 = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [2*DQ_W-1:0] wr_data = '0;
  logic [2*DM_W-1:0] wr_mask = '0;
  logic [DQ_W-1:0] dq_o, dq_i = '0;
  logic [DM_W-1:0] dm_o;
  logic dq_oe, dqs_o, dqs_oe, rd_valid;
  logic rd_strobe = 1'b0, mem_dqs = 1'b0;
  logic [2*DQ_W-1:0] rd_data;

  ddr_dq_datapath #(.DQ_W(DQ_W), .BYTE_W(8), .FIFO_DEPTH(4)) dut_i (
    .clk(clk), .clk90(clk90), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_mask(wr_mask), .dq_o(dq_o), .dq_oe(dq_oe),
    .dm_o(dm_o), .dqs_o(dqs_o), .dqs_oe(dqs_oe), .dq_i(dq_i),
    .rd_strobe(rd_strobe), .rd_valid(rd_valid), .rd_data(rd_data));

  always #2.5 clk = ~clk;
  initial begin #1.25; forever #2.5 clk90 = ~clk90; end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] exp_mem [16];
  logic [31:0] dev_mem [16];
  logic [31:0] expq [$];

  int  wr_base = 0, wbeat = 0;
  real t_dq = 0.0, t_oe = 0.0, t_fall = 0.0;
  logic [DQ_W-1:0] cap_up;
  logic [DM_W-1:0] cap_mup;
  bit have_up = 0;

  always @(dq_o) t_dq = $realtime;
  always @(posedge dqs_oe) t_oe = $realtime;

  always @(posedge dqs_o) if (rst_n) begin
    // R3 data stable a quarter period before the edge
    check(($realtime - t_dq) >= T/4 - 0.01, "R3 rise-edge setup", 32'($rtoi(($realtime - t_dq)*1000)), 32'd1250);
    // R6 data enable at the edge
    check(dq_oe && dqs_oe, "R6 enables at rise edge", {30'd0, dq_oe, dqs_oe}, 32'd3);
    // R5 preamble length
    if (wbeat == 0)
      check(($realtime - t_oe) > T - 0.01 && ($realtime - t_oe) < T + 0.01, "R5 preamble length",
            32'($rtoi(($realtime - t_oe)*1000)), 32'd5000);
    cap_up  = dq_o;
    cap_mup = dm_o;
    have_up = 1;
  end

  always @(negedge dqs_o) if (rst_n && have_up) begin
    logic [31:0] w, m;
    check(($realtime - t_dq) >= T/4 - 0.01, "R3 fall-edge setup", 32'($rtoi(($realtime - t_dq)*1000)), 32'd1250);
    w = {cap_up, dq_o};
    m = '0;
    for (int b = 0; b < DM_W; b++) begin
      if (!cap_mup[b]) m[DQ_W + 8*b +: 8] = 8'hff;
      if (!dm_o[b])    m[8*b +: 8]        = 8'hff;
    end
    dev_mem[(wr_base + wbeat) & 15] = (dev_mem[(wr_base + wbeat) & 15] & ~m) | (w & m);
    wbeat++;
    have_up = 0;
    t_fall = $realtime;
  end

  always @(negedge dqs_oe) if (rst_n) begin
    // R6 postamble and data enable
    check(($realtime - t_fall) > T/2 - 0.01 && ($realtime - t_fall) < T/2 + 0.01, "R6 postamble length",
          32'($rtoi(($realtime - t_fall)*1000)), 32'd2500);
    check(!dq_oe && !dqs_o, "R6 dq released before dqs", {30'd0, dq_oe, dqs_o}, 32'd0);
  end

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) check(0, "R8 unexpected read word", rd_data, 32'd0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(rd_data == e, "R7/R10 read word", rd_data, e);
      end
    end
  end

  task automatic write_burst(input int base, input int n, input bit use_mask);
    wr_base = base;
    wbeat = 0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] d, m;
      logic [3:0] mk;
      d = $urandom;
      mk = use_mask ? 4'($urandom) : 4'd0;
      m = '0;
      for (int b = 0; b < 4; b++) if (!mk[b]) m[8*b +: 8] = 8'hff;
      exp_mem[(base + k) & 15] = (exp_mem[(base + k) & 15] & ~m) | (d & m);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data = d;
      wr_mask = mk;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R2 one strobe period per word
    check(wbeat == n, "R2 beat count", 32'(wbeat), 32'(n));
    check(!dq_oe && !dqs_oe, "R6 idle enables low", {30'd0, dq_oe, dqs_oe}, 32'd0);
  endtask

  task automatic read_burst(input int base, input int n, input real ph, input string tag);
    @(negedge clk);
    #(0.3 + ($urandom % 200) / 100.0);
    for (int k = 0; k < n; k++) expq.push_back(exp_mem[(base + k) & 15]);
    mem_dqs = 1'b0;
    #(T);
    for (int k = 0; k < n; k++) begin
      logic [31:0] w;
      w = dev_mem[(base + k) & 15];
      dq_i = w[31:16]; mem_dqs = 1'b1;
      #(ph) rd_strobe = 1'b1;
      #(T/2 - ph) dq_i = w[15:0]; mem_dqs = 1'b0;
      #(ph) rd_strobe = 1'b0;
      #(T/2 - ph);
    end
    dq_i = 16'($urandom);
    repeat (10) @(negedge clk);
    check(expq.size() == 0, {tag, " all words delivered"}, 32'(expq.size()), 32'd0);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) begin
      exp_mem[a] = 32'h1357_0000 + 32'(a * 32'h0001_0203);
      dev_mem[a] = exp_mem[a];
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!dq_oe && !dqs_oe && !dqs_o && !rd_valid, "R1 reset outputs",
          {28'd0, dq_oe, dqs_oe, dqs_o, rd_valid}, 32'd0);

    write_burst(0, 4, 0);                  // R2 plain burst
    read_burst(0, 4, 1.25, "R7 centred");
    write_burst(4, 8, 1);                  // R4 masked bytes keep old data
    read_burst(4, 8, 0.9, "R4 masked readback");
    write_burst(13, 1, 0);                 // single-word burst
    read_burst(13, 1, 1.6, "R8 single word");
    read_burst(0, 2, 0.5, "R10 early phase");
    read_burst(0, 2, 1.99, "R10 late phase");
    for (int i = 0; i < 4; i++)
      read_burst(4 * i, 3, 0.5 + ($urandom % 150) / 100.0, "R10 random phase");
    write_burst(0, 12, 1);
    read_burst(0, 12, 1.1, "R9 long back-to-back");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule